// File: doc/BRIEF.md
# Interval Tick Generator

The interval tick generator turns a free-running timebase into a slow periodic event. The block keeps its own 64-bit timebase counter, which advances by one on every clock cycle in which the tick-enable input is high. A two-bit period select picks one of four counter bits as a tap. Each time the chosen tap goes from 0 to 1, a sticky event flag is set. Because the tap keeps toggling, the generator re-arms itself without any help from software.

Software clears the flag by writing a one to it. A maskable interrupt line mirrors the flag while the interrupt enable is high. The four periods are powers of two. Two parameters fix them: the base exponent, and the exponent step between neighbouring selections. With the defaults the four periods are 512, 8192, 131072 and 2097152 ticks.

Top module: `interval_tick_gen`

## Requirements
- R1: After reset the event flag, the interrupt output and the timebase count are all zero.
- R2: The timebase count rises by exactly one, wrapping modulo 2^64, at each clock edge where tbTick is high. It holds its value when tbTick is low.
- R3: periodSel value s (0 to 3) selects a period of 2^(B+s*S) ticks, where B is PERIOD_BASE_LOG2 and S is PERIOD_STEP_LOG2. The watched tap is count bit B+s*S-1. The flag is set on the clock edge that ends a cycle in which this bit reads 1 after reading 0 in the previous cycle.
- R4: Once set, the flag stays set until it is cleared. Later periods keep producing events with no reload or re-arm action.
- R5: A cycle with clrWrite high and clrData equal to 1 clears the flag at the next edge. A cycle with clrWrite high and clrData equal to 0 leaves the flag unchanged.
- R6: When an event and a clear fall in the same cycle, the event wins and the flag ends up set.
- R7: irq equals the flag ANDed with intEn, with no register in between. The flag is set whether or not intEn is high.
- R8: No event is flagged in a cycle whose periodSel differs from the previous cycle's value. This holds even when the newly selected bit is 1 and the old one was 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tbTick | input | 1 | Timebase advance enable |
| periodSel | input | 2 | Period selection (0 shortest, 3 longest) |
| intEn | input | 1 | Interrupt enable |
| clrWrite | input | 1 | Status write strobe |
| clrData | input | 1 | Status write data; a one clears the flag |
| tbCount | output | TB_WIDTH | Current timebase count |
| tickFlag | output | 1 | Sticky event flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a base exponent of 3 and a step of 1, so the taps are bits 2 to 5 and the periods are 8, 16, 32 and 64 ticks. At those sizes every selection fires many times within a few hundred cycles. That brings the repeated re-arm, the collision of a clear with an event, and hopping between selections while the count sits at arbitrary phases all within reach. With the default exponents these cases would need millions of ticks. The tick enable is also gated on alternate cycles, to show that periods are counted in ticks and not in clocks.

// File: rtl/itg_pkg.sv
package itg_pkg;
  localparam int unsigned NUM_TAPS = 4;
  localparam int unsigned SEL_W    = $clog2(NUM_TAPS);

  typedef struct packed {
    logic setFlag;
    logic clrFlag;
  } itgStrobes_t;
endpackage

// File: rtl/itg_datapath.sv
module itg_datapath
  import itg_pkg::*;
#(
  parameter int unsigned TB_WIDTH         = 64,
  parameter int unsigned PERIOD_BASE_LOG2 = 9,
  parameter int unsigned PERIOD_STEP_LOG2 = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tbTick,
  input  logic [SEL_W-1:0]    periodSel,
  input  itgStrobes_t         strobes,
  output logic                tapBit,
  output logic [TB_WIDTH-1:0] tbCount,
  output logic                flag
);
  localparam int unsigned TAP_LO = PERIOD_BASE_LOG2 - 1;
  localparam logic [TB_WIDTH-1:0] CNT_ONE = {{(TB_WIDTH-1){1'b0}}, 1'b1};

  logic [TB_WIDTH-1:0] countQ;
  logic                flagQ;
  logic [NUM_TAPS-1:0] tapBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (tbTick) begin
      countQ <= countQ + CNT_ONE;
    end
  end

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
    assign tapBits[g] = countQ[TAP_LO + g * PERIOD_STEP_LOG2];
  end

  assign tapBit = tapBits[periodSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (strobes.setFlag) begin
      flagQ <= 1'b1;
    end else if (strobes.clrFlag) begin
      flagQ <= 1'b0;
    end
  end

  assign tbCount = countQ;
  assign flag    = flagQ;

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    tbTick |=> countQ == $past(countQ) + CNT_ONE);
  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !tbTick |=> $stable(countQ));
  assert_event_sets_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setFlag |=> flagQ);
  assert_clear_works_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrFlag && !strobes.setFlag) |=> !flagQ);
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !strobes.clrFlag) |=> flagQ);
endmodule

// File: rtl/itg_control.sv
module itg_control
  import itg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] periodSel,
  input  logic             tapBit,
  input  logic             clrWrite,
  input  logic             clrData,
  output itgStrobes_t      strobes
);
  logic             tapQ;
  logic [SEL_W-1:0] selQ;
  logic             selHeld;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tapQ <= 1'b0;
      selQ <= '0;
    end else begin
      tapQ <= tapBit;
      selQ <= periodSel;
    end
  end

  assign selHeld = (periodSel == selQ);

  always_comb begin
    strobes         = '0;
    strobes.setFlag = tapBit && !tapQ && selHeld;
    strobes.clrFlag = clrWrite && clrData;
  end

  assert_no_back_to_back_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setFlag |=> !strobes.setFlag);
endmodule

// File: rtl/interval_tick_gen.sv
module interval_tick_gen
  import itg_pkg::*;
#(
  parameter int unsigned TB_WIDTH         = 64,
  parameter int unsigned PERIOD_BASE_LOG2 = 9,
  parameter int unsigned PERIOD_STEP_LOG2 = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tbTick,
  input  logic [1:0]          periodSel,
  input  logic                intEn,
  input  logic                clrWrite,
  input  logic                clrData,
  output logic [TB_WIDTH-1:0] tbCount,
  output logic                tickFlag,
  output logic                irq
);
  itgStrobes_t strobes;
  logic        tapBit;
  logic        flag;

  itg_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .periodSel (periodSel),
    .tapBit    (tapBit),
    .clrWrite  (clrWrite),
    .clrData   (clrData),
    .strobes   (strobes)
  );

  itg_datapath #(
    .TB_WIDTH         (TB_WIDTH),
    .PERIOD_BASE_LOG2 (PERIOD_BASE_LOG2),
    .PERIOD_STEP_LOG2 (PERIOD_STEP_LOG2)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .tbTick    (tbTick),
    .periodSel (periodSel),
    .strobes   (strobes),
    .tapBit    (tapBit),
    .tbCount   (tbCount),
    .flag      (flag)
  );

  assign tickFlag = flag;
  assign irq      = flag & intEn;

  assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> tickFlag);
  assert_irq_masked_R7: assert property (@(posedge clk) disable iff (!rstN)
    !intEn |-> !irq);
  assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!tickFlag && tbCount == '0));
endmodule

// File: tb/interval_tick_gen_tb.sv
module interval_tick_gen_tb;
  localparam int TBW  = 64;
  localparam int BASE = 3;
  localparam int STEP = 1;

  logic clk = 1'b0, rstN = 1'b0, tbTick = 1'b0, intEn = 1'b0;
  logic clrWrite = 1'b0, clrData = 1'b0;
  logic [1:0] periodSel = 2'd0;
  logic [TBW-1:0] tbCount;
  logic tickFlag, irq;

  interval_tick_gen #(
    .TB_WIDTH(TBW), .PERIOD_BASE_LOG2(BASE), .PERIOD_STEP_LOG2(STEP)
  ) u_dut (
    .clk(clk), .rstN(rstN), .tbTick(tbTick), .periodSel(periodSel),
    .intEn(intEn), .clrWrite(clrWrite), .clrData(clrData),
    .tbCount(tbCount), .tickFlag(tickFlag), .irq(irq)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic           flag;
    logic           irq;
    logic [TBW-1:0] cnt;
    string          req;
  } expItem_t;

  expItem_t expQ[$];
  int testsRun = 0;
  int testsFailed = 0;

  logic [TBW-1:0] mCount, mPrevCount;
  logic [1:0]     mPrevSel;
  logic           mFlag;

  function automatic logic tapOf(input logic [TBW-1:0] c, input logic [1:0] s);
    return c[BASE - 1 + int'(s) * STEP];
  endfunction

  task automatic resetModel();
    mCount = '0; mPrevCount = '0; mPrevSel = 2'd0; mFlag = 1'b0;
  endtask

  // Driver: called at a falling edge; applies inputs and queues the outcome of the next rising edge.
  task automatic drive(input logic tk, input logic [1:0] sel, input logic ie,
                       input logic cw, input logic cd, input string req);
    logic rise;
    expItem_t it;
    tbTick = tk; periodSel = sel; intEn = ie; clrWrite = cw; clrData = cd;
    rise = tapOf(mCount, sel) & ~tapOf(mPrevCount, mPrevSel) & (sel == mPrevSel);
    mFlag = rise | (mFlag & ~(cw & cd));
    mPrevCount = mCount;
    mPrevSel = sel;
    mCount = mCount + TBW'(tk);
    it.flag = mFlag; it.irq = mFlag & ie; it.cnt = mCount; it.req = req;
    expQ.push_back(it);
    @(negedge clk);
  endtask

  task automatic checkNow(input logic f, input logic i, input logic [TBW-1:0] c, input string req);
    testsRun++;
    if (tickFlag !== f || irq !== i || tbCount !== c) begin
      testsFailed++;
      $display("FAIL %s: flag=%0b irq=%0b count=%0d, expected flag=%0b irq=%0b count=%0d",
               req, tickFlag, irq, tbCount, f, i, c);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
  endtask

  // Monitor: compares each queued expectation after the rising edge it refers to.
  initial begin
    expItem_t it;
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        it = expQ.pop_front();
        testsRun++;
        if (tickFlag !== it.flag || irq !== it.irq || tbCount !== it.cnt) begin
          testsFailed++;
          $display("FAIL %s: flag=%0b irq=%0b count=%0d, expected flag=%0b irq=%0b count=%0d",
                   it.req, tickFlag, irq, tbCount, it.flag, it.irq, it.cnt);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog (all requirements): run hung, expected completion");
    summary();
    $finish;
  end

  initial begin
    resetModel();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkNow(1'b0, 1'b0, '0, "R1");

    // R3: shortest period, interrupt masked
    for (int i = 0; i < 14; i++) drive(1'b1, 2'd0, 1'b0, 1'b0, 1'b0, "R3");
    // R5: zero write is ignored, one write clears
    drive(1'b1, 2'd0, 1'b0, 1'b1, 1'b0, "R5");
    drive(1'b1, 2'd0, 1'b0, 1'b0, 1'b0, "R5");
    drive(1'b1, 2'd0, 1'b0, 1'b1, 1'b1, "R5");
    for (int i = 0; i < 3; i++) drive(1'b1, 2'd0, 1'b0, 1'b0, 1'b0, "R5");
    // R7: interrupt follows flag when enabled, toggling enable
    for (int i = 0; i < 20; i++) drive(1'b1, 2'd0, 1'b1, 1'b0, 1'b0, "R7");
    drive(1'b1, 2'd0, 1'b0, 1'b0, 1'b0, "R7");
    drive(1'b1, 2'd0, 1'b1, 1'b1, 1'b1, "R7");
    // R2: gated ticks, period counted in ticks
    for (int i = 0; i < 60; i++) drive(1'(i % 2), 2'd1, 1'b1, 1'b0, 1'b0, "R2");
    // R6: clear held high, events still land
    for (int i = 0; i < 40; i++) drive(1'b1, 2'd0, 1'b1, 1'b1, 1'b1, "R6");
    // R8: hop between selections with clear held so each event shows alone
    for (int i = 0; i < 60; i++) drive(1'b1, 2'((i / 3) % 4), 1'b0, 1'b1, 1'b1, "R8");
    // R4: longest period, sticky across several events
    drive(1'b1, 2'd3, 1'b1, 1'b1, 1'b1, "R4");
    for (int i = 0; i < 150; i++) drive(1'b1, 2'd3, 1'b1, 1'b0, 1'b0, "R4");
    // R3: middle selection, periodic re-arm
    for (int i = 0; i < 70; i++) drive(1'b1, 2'd2, 1'b1, 1'(i % 32 == 0), 1'b1, "R3");

    @(posedge clk); #3;
    // R1: reset in mid-run
    @(negedge clk);
    rstN = 1'b0;
    tbTick = 1'b0; intEn = 1'b1; clrWrite = 1'b0; clrData = 1'b0; periodSel = 2'd0;
    #1;
    checkNow(1'b0, 1'b0, '0, "R1");
    @(negedge clk);
    rstN = 1'b1;
    resetModel();
    checkNow(1'b0, 1'b0, '0, "R1");
    for (int i = 0; i < 10; i++) drive(1'b1, 2'd0, 1'b1, 1'b0, 1'b0, "R1");

    @(posedge clk); #3;
    summary();
    $finish;
  end
endmodule